// File: doc/BRIEF.md
# Stereo Serial Audio Port (I2S and Justified Framing)

This block is a stereo serial audio port that works as bus master. It divides the system clock down to a serial bit clock (`sck`). It drives a word-select line (`ws`) that toggles once per channel half-frame. On the same bus it sends one 16-bit sample per channel on `sd_out` and collects one sample per channel from `sd_in`. A static 11-bit mode word sets the framing. The framing is either left-justified, with the MSB in the first or the second bit period of a half (the second is I2S framing), or right-justified, with the LSB in the last bit period of a half. The mode word also sets which `ws` level carries the left channel, the width of the received words, and how each received word is reduced to 16 bits.

The internal logic loads a transmit pair with a one-cycle `tx_valid` strobe. The port keeps that pair and sends it in every frame until a new strobe arrives. A received pair is presented once per frame with a one-cycle `rx_valid` pulse. A received word can be cut to its top 16 bits, rounded to 16 bits with saturation, or attenuated in 6 dB steps before the saturating rounding. The mode word is expected to change only while `rst` is high.

Top module: `i2s_serial_port`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `sck`, `ws`, `sd_out` and `rx_valid` are 0.
- R2: `sck` changes level every `SCK_DIV` system clocks, so one bit period is 2*`SCK_DIV` clocks. `ws` changes only on a falling `sck` edge, and each half-frame lasts `SLOT_BITS` bit periods.
- R3: With mode bit 0 = 0 (left-justified), the sample MSB is sent in bit period 0 of a half when mode bit 1 = 0, or in bit period 1 when mode bit 1 = 1. The remaining 15 bits follow MSB first, and every other period of the half carries 0. Mode 0x406 is I2S framing with 16-bit cropped reception.
- R4: With mode bit 0 = 1 (right-justified), the LSB is sent in the last bit period of a half and all leading periods carry the sign bit. Mode bit 1 has no effect on transmit or receive framing.
- R5: With mode bit 2 = 0, the half where `ws` is high carries the left channel. With mode bit 2 = 1, it carries the right channel.
- R6: `sd_out` changes only on a falling `sck` edge. `sd_in` is sampled when `sck` rises.
- R7: Mode bits 9:8 set the received word width: 00 gives 16 bits, 01 gives 20 bits, and 10 or 11 gives 24 bits. Left-justified words are taken MSB first from the MSB period onward. Right-justified words are the last N periods of the half. Bits beyond the word are ignored.
- R8: With mode bit 10 = 1, the received word, MSB-aligned to 24 bits, is cut to its top 16 bits, and mode bits 7:3 have no effect.
- R9: With mode bits 10 and 3 both 0, the 24-bit aligned word is rounded to nearest (half rounds up) to 16 bits, and a positive overflow saturates to 0x7FFF.
- R10: With mode bit 10 = 0 and bit 3 = 1, the aligned word is divided by 2^A, where A is mode bits 7:4 (6 dB per step). The result is rounded to nearest and saturated to 16 bits.
- R11: `rx_valid` pulses for one cycle once per frame, at the end of the right half that follows a received left half. `rx_left` and `rx_right` change only with that pulse.
- R12: A `tx_valid` strobe stores `tx_left`/`tx_right`. The stored pair is taken at the start of each left half, so an unchanged pair is sent again in every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 11 | Framing and receive-format mode word |
| tx_left | input | 16 | Left transmit sample |
| tx_right | input | 16 | Right transmit sample |
| tx_valid | input | 1 | Strobe that stores the transmit pair |
| rx_left | output | 16 | Left received sample |
| rx_right | output | 16 | Right received sample |
| rx_valid | output | 1 | One-cycle pulse for a new received pair |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word-select / channel line |
| sd_out | output | 1 | Serial data out |
| sd_in | input | 1 | Serial data in |

## Verification
The bound checker covers the bus timing on every cycle. It checks the bit-clock half period, that `ws` and `sd_out` move only with a falling `sck`, that `rx_valid` lasts a single cycle, and that the received pair changes only with that pulse. Other behaviours can be shown only by the bench scenarios, which decode whole half-frames. These are the bit placement for each framing and delay, the polarity swap, sign filling, resolution windows, and the crop, round, saturation and attenuation arithmetic. Some scenarios loop `sd_out` back to `sd_in`. Others drive patterns whose bits lie outside the selected word.

// File: rtl/isp_pkg.sv
package isp_pkg;

    localparam int SAMPLE_W = 16;
    localparam int ACC_W    = 24;

    // Field order follows the mode word bit positions (bit 10 down to bit 0).
    typedef struct packed {
        logic       crop_en;     // 10
        logic [1:0] rx_res;      // 9:8
        logic [3:0] att_steps;   // 7:4
        logic       att_en;      // 3
        logic       ws_inv;      // 2
        logic       msb_late;    // 1
        logic       right_just;  // 0
    } isp_mode_t;

    function automatic int res_bits(input logic [1:0] r);
        case (r)
            2'b00:   return 16;
            2'b01:   return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/isp_clkgen.sv
module isp_clkgen #(
    parameter int SCK_DIV   = 2,
    parameter int SLOT_BITS = 32,
    parameter int CNT_W     = 1,
    parameter int PER_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    output logic             sck,
    output logic             ws,
    output logic [PER_W-1:0] per,
    output logic [PER_W-1:0] nxt_per,
    output logic             nxt_ws,
    output logic             rise_ev,
    output logic             fall_ev,
    output logic             wrap_ev
);

    localparam logic [PER_W-1:0] LAST_PER = PER_W'(SLOT_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SCK_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sck;
        logic             ws;
        logic [PER_W-1:0] per;
    } gen_t;

    gen_t g_d, g_q;

    always_comb begin
        g_d     = g_q;
        rise_ev = 1'b0;
        fall_ev = 1'b0;
        wrap_ev = 1'b0;
        if (g_q.cnt == LAST_CNT) begin
            g_d.cnt = '0;
            g_d.sck = ~g_q.sck;
            if (!g_q.sck) begin
                rise_ev = 1'b1;
            end else begin
                fall_ev = 1'b1;
                if (g_q.per == LAST_PER) begin
                    g_d.per = '0;
                    g_d.ws  = ~g_q.ws;
                    wrap_ev = 1'b1;
                end else begin
                    g_d.per = g_q.per + 1'b1;
                end
            end
        end else begin
            g_d.cnt = g_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q.cnt <= '0;
            g_q.sck <= 1'b0;
            g_q.ws  <= 1'b0;
            g_q.per <= LAST_PER;
        end else begin
            g_q <= g_d;
        end
    end

    assign sck     = g_q.sck;
    assign ws      = g_q.ws;
    assign per     = g_q.per;
    assign nxt_per = g_d.per;
    assign nxt_ws  = g_d.ws;

endmodule

// File: rtl/isp_tx.sv
module isp_tx
    import isp_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int PER_W     = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  isp_mode_t           mode,
    input  logic                fall_ev,
    input  logic                wrap_ev,
    input  logic [PER_W-1:0]    nxt_per,
    input  logic                nxt_ws,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    input  logic                tx_valid,
    output logic                sd_out
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] hold_l;
        logic [SAMPLE_W-1:0] hold_r;
        logic [SAMPLE_W-1:0] cur_l;
        logic [SAMPLE_W-1:0] cur_r;
        logic                sd;
    } tx_t;

    tx_t t_d, t_q;

    function automatic logic pick_bit(input logic [SAMPLE_W-1:0] s, input int p,
                                      input isp_mode_t m);
        int j;
        int k;
        j = SLOT_BITS - 1 - p;
        k = p - int'(m.msb_late);
        if (m.right_just) begin
            if (j < SAMPLE_W) return s[j[3:0]];
            return s[SAMPLE_W-1];
        end
        if (k >= 0 && k < SAMPLE_W) return s[4'(SAMPLE_W - 1 - k)];
        return 1'b0;
    endfunction

    logic next_is_left;

    always_comb begin
        t_d          = t_q;
        next_is_left = nxt_ws ^ mode.ws_inv;
        if (tx_valid) begin
            t_d.hold_l = tx_left;
            t_d.hold_r = tx_right;
        end
        if (wrap_ev && next_is_left) begin
            t_d.cur_l = t_q.hold_l;
            t_d.cur_r = t_q.hold_r;
        end
        if (fall_ev) begin
            t_d.sd = pick_bit(next_is_left ? t_d.cur_l : t_d.cur_r, int'(nxt_per), mode);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign sd_out = t_q.sd;

endmodule

// File: rtl/isp_scale.sv
module isp_scale
    import isp_pkg::*;
(
    input  isp_mode_t           mode,
    input  logic [ACC_W-1:0]    word,
    output logic [SAMPLE_W-1:0] sample
);

    logic signed [31:0] ext;
    logic signed [31:0] sum;
    logic signed [31:0] quo;
    int                 sh;

    always_comb begin
        sh  = mode.att_en ? int'(mode.att_steps) : 0;
        ext = {{(32-ACC_W){word[ACC_W-1]}}, word};
        sum = ext + (32'sd1 <<< (sh + 7));
        quo = sum >>> (sh + 8);
        if (mode.crop_en)          sample = word[ACC_W-1 -: SAMPLE_W];
        else if (quo > 32'sd32767) sample = 16'h7FFF;
        else                       sample = quo[SAMPLE_W-1:0];
    end

endmodule

// File: rtl/isp_rx.sv
module isp_rx
    import isp_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int PER_W     = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  isp_mode_t           mode,
    input  logic                rise_ev,
    input  logic                wrap_ev,
    input  logic [PER_W-1:0]    per,
    input  logic                ws,
    input  logic                sd_in,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);

    typedef struct packed {
        logic [ACC_W-1:0]    acc;
        logic                have_left;
        logic [SAMPLE_W-1:0] lhold;
        logic [SAMPLE_W-1:0] out_l;
        logic [SAMPLE_W-1:0] out_r;
        logic                vld;
    } rx_t;

    rx_t r_d, r_q;
    logic [SAMPLE_W-1:0] reduced;
    int n;
    int j;
    int k;

    isp_scale u_scale (
        .mode   (mode),
        .word   (r_q.acc),
        .sample (reduced)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        n       = res_bits(mode.rx_res);
        j       = SLOT_BITS - 1 - int'(per);
        k       = int'(per) - int'(mode.msb_late);
        if (rise_ev) begin
            if (mode.right_just) begin
                if (j < n) r_d.acc[5'(j + ACC_W - n)] = sd_in;
            end else if (k >= 0 && k < n) begin
                r_d.acc[5'(ACC_W - 1 - k)] = sd_in;
            end
        end
        if (wrap_ev) begin
            r_d.acc = '0;
            if (ws ^ mode.ws_inv) begin
                r_d.lhold     = reduced;
                r_d.have_left = 1'b1;
            end else if (r_q.have_left) begin
                r_d.out_l     = r_q.lhold;
                r_d.out_r     = reduced;
                r_d.vld       = 1'b1;
                r_d.have_left = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign rx_left  = r_q.out_l;
    assign rx_right = r_q.out_r;
    assign rx_valid = r_q.vld;

endmodule

// File: rtl/i2s_serial_port.sv
module i2s_serial_port
    import isp_pkg::*;
#(
    parameter int SCK_DIV   = 2,
    parameter int SLOT_BITS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [10:0] mode,
    input  logic [15:0] tx_left,
    input  logic [15:0] tx_right,
    input  logic        tx_valid,
    output logic [15:0] rx_left,
    output logic [15:0] rx_right,
    output logic        rx_valid,
    output logic        sck,
    output logic        ws,
    output logic        sd_out,
    input  logic        sd_in
);

    localparam int CNT_W = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
    localparam int PER_W = $clog2(SLOT_BITS);

    isp_mode_t        mcfg;
    logic [PER_W-1:0] per;
    logic [PER_W-1:0] nxt_per;
    logic             nxt_ws;
    logic             rise_ev;
    logic             fall_ev;
    logic             wrap_ev;

    assign mcfg = isp_mode_t'(mode);

    isp_clkgen #(
        .SCK_DIV   (SCK_DIV),
        .SLOT_BITS (SLOT_BITS),
        .CNT_W     (CNT_W),
        .PER_W     (PER_W)
    ) u_gen (
        .clk     (clk),
        .rst     (rst),
        .sck     (sck),
        .ws      (ws),
        .per     (per),
        .nxt_per (nxt_per),
        .nxt_ws  (nxt_ws),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .wrap_ev (wrap_ev)
    );

    isp_tx #(
        .SLOT_BITS (SLOT_BITS),
        .PER_W     (PER_W)
    ) u_tx (
        .clk      (clk),
        .rst      (rst),
        .mode     (mcfg),
        .fall_ev  (fall_ev),
        .wrap_ev  (wrap_ev),
        .nxt_per  (nxt_per),
        .nxt_ws   (nxt_ws),
        .tx_left  (tx_left),
        .tx_right (tx_right),
        .tx_valid (tx_valid),
        .sd_out   (sd_out)
    );

    isp_rx #(
        .SLOT_BITS (SLOT_BITS),
        .PER_W     (PER_W)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .mode     (mcfg),
        .rise_ev  (rise_ev),
        .wrap_ev  (wrap_ev),
        .per      (per),
        .ws       (ws),
        .sd_in    (sd_in),
        .rx_left  (rx_left),
        .rx_right (rx_right),
        .rx_valid (rx_valid)
    );

endmodule

// File: rtl/isp_port_chk.sv
module isp_port_chk #(
    parameter int SCK_DIV = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        sck,
    input logic        ws,
    input logic        sd_out,
    input logic        rx_valid,
    input logic [15:0] rx_left,
    input logic [15:0] rx_right
);

    int   gap;
    logic sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap      <= 0;
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= sck;
            gap      <= (sck != sck_prev) ? 1 : gap + 1;
        end
    end

    AST_SCK_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (sck != sck_prev) |-> (gap == SCK_DIV)); // R2
    AST_WS_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        $changed(ws) |-> $fell(sck)); // R2
    AST_SDOUT_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        $changed(sd_out) |-> $fell(sck)); // R6
    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R11
    AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
        ($changed(rx_left) || $changed(rx_right)) |-> rx_valid); // R11

endmodule

bind i2s_serial_port isp_port_chk #(.SCK_DIV(SCK_DIV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sck      (sck),
    .ws       (ws),
    .sd_out   (sd_out),
    .rx_valid (rx_valid),
    .rx_left  (rx_left),
    .rx_right (rx_right)
);

// File: tb/tb_i2s_serial_port.sv
`timescale 1ns/1ps
module tb_i2s_serial_port;

    localparam int DIV   = 2;
    localparam int SLOT  = 32;
    localparam int FRAME = 2 * SLOT * 2 * DIV;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] mode = '0;
    logic [15:0] tx_left = '0, tx_right = '0;
    logic        tx_valid = 1'b0;
    logic [15:0] rx_left, rx_right;
    logic        rx_valid, sck, ws, sd_out, sd_in;
    logic        loop = 1'b1;
    logic        drv_bit = 1'b0;
    logic [31:0] pat [2];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    assign sd_in = loop ? sd_out : drv_bit;

    i2s_serial_port #(.SCK_DIV(DIV), .SLOT_BITS(SLOT)) dut (
        .clk(clk), .rst(rst), .mode(mode), .tx_left(tx_left), .tx_right(tx_right),
        .tx_valid(tx_valid), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid),
        .sck(sck), .ws(ws), .sd_out(sd_out), .sd_in(sd_in)
    );

    // bus monitor / serial source
    logic        psck = 1'b0, pws = 1'b0;
    int          bidx = 0;
    int          half_len = 0;
    int          sck_gap = 0, sck_per = 0;
    int          rx_cnt = 0;
    logic [31:0] cap = '0;
    logic [31:0] ws_word [2];
    logic [15:0] got_l = '0, got_r = '0;

    always @(negedge clk) begin
        sck_gap++;
        if (sck && !psck) begin
            if (bidx < 32) cap[31-bidx] = sd_out;
            sck_per = sck_gap;
            sck_gap = 0;
        end
        if (!sck && psck) begin
            if (ws != pws) begin
                ws_word[pws] = cap;
                half_len = bidx + 1;
                bidx = 0;
            end else begin
                bidx++;
            end
            if (bidx < 32) drv_bit = pat[ws][31-bidx];
        end
        if (rx_valid) begin
            got_l = rx_left;
            got_r = rx_right;
            rx_cnt++;
        end
        psck = sck;
        pws  = ws;
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual cycles %0d expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- reference model from the requirements ----------------
    function automatic logic [31:0] tx_word(input logic [15:0] s, input logic [10:0] m);
        if (m[0]) return {{16{s[15]}}, s};
        return {s, 16'h0} >> m[1];
    endfunction

    function automatic logic [15:0] ref_reduce(input logic [23:0] a, input logic [10:0] m);
        int v, at, q;
        if (m[10]) return a[23:8];
        at = m[3] ? int'(m[7:4]) : 0;
        v  = int'({{8{a[23]}}, a});
        q  = (v + (1 <<< (at + 7))) >>> (at + 8);
        if (q > 32767) q = 32767;
        return q[15:0];
    endfunction

    function automatic logic [15:0] ref_rx(input logic [31:0] w, input logic [10:0] m);
        int n;
        logic [31:0] sh;
        logic [23:0] a;
        n = (m[9:8] == 2'b00) ? 16 : (m[9:8] == 2'b01) ? 20 : 24;
        if (m[0]) begin
            sh = w & ((32'd1 << n) - 1);
            a  = 24'(sh << (24 - n));
        end else begin
            sh = w << m[1];
            a  = sh[31:8] & ~((24'd1 << (24 - n)) - 1);
        end
        return ref_reduce(a, m);
    endfunction

    function automatic int left_lvl(input logic [10:0] m);
        return m[2] ? 0 : 1;
    endfunction

    // ---------------- scenario helpers ----------------
    task automatic run_cfg(input logic [10:0] m, input logic [15:0] l, input logic [15:0] r,
                           input logic lp);
        @(negedge clk);
        rst  = 1'b1;
        mode = m;
        loop = lp;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        tx_left  = l;
        tx_right = r;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (4 * FRAME) @(negedge clk);
    endtask

    task automatic check_loop(input string req, input logic [10:0] m,
                              input logic [15:0] l, input logic [15:0] r);
        int ll;
        ll = left_lvl(m);
        check({req, " tx left half"},  ws_word[ll],     tx_word(l, m));
        check({req, " tx right half"}, ws_word[1 - ll], tx_word(r, m));
        check({req, " rx left"},  {16'h0, got_l}, {16'h0, ref_rx(tx_word(l, m), m)});
        check({req, " rx right"}, {16'h0, got_r}, {16'h0, ref_rx(tx_word(r, m), m)});
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 sck in reset", {31'h0, sck}, 32'h0);
        check("R1 ws in reset", {31'h0, ws}, 32'h0);
        check("R1 sd_out in reset", {31'h0, sd_out}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rx_valid after reset", {31'h0, rx_valid}, 32'h0);
    endtask

    task automatic t_i2s_crop();
        run_cfg(11'h406, 16'h1234, 16'hFEDC, 1'b1);
        check_loop("R3 R5 R8 i2s", 11'h406, 16'h1234, 16'hFEDC);
        check("R2 sck period", sck_per, 2 * DIV);
        check("R2 half length", half_len, SLOT);
    endtask

    task automatic t_lj_round();
        run_cfg(11'h000, 16'h8001, 16'h7FFF, 1'b1);
        check_loop("R3 R9 lj early", 11'h000, 16'h8001, 16'h7FFF);
    endtask

    task automatic t_rj();
        run_cfg(11'h401, 16'h8421, 16'h0F0F, 1'b1);
        check_loop("R4 rj16", 11'h401, 16'h8421, 16'h0F0F);
        run_cfg(11'h603, 16'h8421, 16'h0F0F, 1'b1);
        check_loop("R4 R7 rj24 late ignored", 11'h603, 16'h8421, 16'h0F0F);
        check("R4 sign fill", ws_word[1], 32'hFFFF8421);
    endtask

    task automatic t_driven();
        logic [10:0] m;
        pat[1] = {1'b1, 24'h7FFFF0, 7'h55};
        pat[0] = {1'b0, 24'h123480, 7'h2A};
        m = 11'h202;
        run_cfg(m, 16'h0, 16'h0, 1'b0);
        check("R9 R7 saturate left", {16'h0, got_l}, {16'h0, ref_rx(pat[1], m)});
        check("R9 R7 round right", {16'h0, got_r}, {16'h0, ref_rx(pat[0], m)});
        check("R9 saturate value", {16'h0, got_l}, 32'h7FFF);
        m = 11'h002;
        run_cfg(m, 16'h0, 16'h0, 1'b0);
        check("R7 res16 left", {16'h0, got_l}, {16'h0, ref_rx(pat[1], m)});
        check("R7 res16 right", {16'h0, got_r}, {16'h0, ref_rx(pat[0], m)});
        m = 11'h302;
        run_cfg(m, 16'h0, 16'h0, 1'b0);
        check("R7 reserved as 24 right", {16'h0, got_r}, {16'h0, ref_rx(pat[0], m)});
        m = 11'h101;
        run_cfg(m, 16'h0, 16'h0, 1'b0);
        check("R7 rj20 left", {16'h0, got_l}, {16'h0, ref_rx(pat[1], m)});
        check("R7 rj20 right", {16'h0, got_r}, {16'h0, ref_rx(pat[0], m)});
    endtask

    task automatic t_atten();
        run_cfg(11'h03A, 16'h1000, 16'h8005, 1'b1);
        check_loop("R10 atten3", 11'h03A, 16'h1000, 16'h8005);
        check("R10 atten3 value", {16'h0, got_l}, 32'h0200);
        run_cfg(11'h43A, 16'h1000, 16'h8005, 1'b1);
        check("R8 crop ignores atten left", {16'h0, got_l}, 32'h1000);
        check("R8 crop ignores atten right", {16'h0, got_r}, 32'h8005);
    endtask

    task automatic t_hold();
        int c0;
        run_cfg(11'h406, 16'hA5A5, 16'h5A5A, 1'b1);
        c0 = rx_cnt;
        repeat (4 * FRAME) @(negedge clk);
        check("R11 one pair per frame", rx_cnt - c0, 4);
        check("R12 pair repeats", {16'h0, got_l}, 32'hA5A5);
        tx_left  = 16'h0001;
        tx_right = 16'hFFFE;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        tx_left  = 16'hDEAD;
        repeat (3 * FRAME) @(negedge clk);
        check_loop("R12 new pair", 11'h406, 16'h0001, 16'hFFFE);
    endtask

    initial begin
        pat[0] = '0;
        pat[1] = '0;
        ws_word[0] = '0;
        ws_word[1] = '0;
        t_reset();
        t_i2s_crop();
        t_lj_round();
        t_rj();
        t_driven();
        t_atten();
        t_hold();
        summary();
        $finish;
    end

endmodule